// File: doc/BRIEF.md
# Page Private/Shared Classifier

This block decides, for each memory access in a multicore system, whether the access needs coherence tracking. It keeps its decision per page, not per cache block. A small fully associative table holds one record per tracked page. Each record has a valid flag, the page number, the core that owns the page and a shared flag. The first core to touch an untracked page becomes its owner, and the page is private. Accesses from that owner to a private page are reported as non-coherent, so the directory need not allocate anything for them.

When a different core touches a private page, the block stalls that request and marks the page shared. It then walks the page block by block and issues one flush request per block to the owner's cache. Once the owner has accepted the final flush, the stalled request completes as a coherent access. A shared page stays shared for as long as its record lives.

When a miss finds the table full, a round-robin pointer selects a victim entry. If the victim is shared, the new page takes its slot at once. If the victim is private, the victim page is flushed from its owner first, because no record of it will remain. The new page is then installed.

Top module: `page_share_classifier`

## Requirements
- R1: After reset the table holds no records, `req_ready` is high and `flush_valid` is low; the first access to any page is reported with `resp_coherent` low.
- R2: A request to an untracked page while a table slot is free completes in the same cycle (`req_ready` high) with `resp_coherent` low, and records the requesting core as owner of the page.
- R3: A request from the owner to its own private page completes in the same cycle with `resp_coherent` low.
- R4: A request from a non-owner to a private page is stalled (`req_ready` low) from its first cycle until the owner accepts the last flush request.
- R5: A recovery issues exactly 2^(PAGE_BITS-BLOCK_BITS) flush requests (64 by default). They are addressed to the owning core on `flush_core`. Their addresses are the block-aligned addresses of the page, in ascending order starting at block 0 and stepping by 2^BLOCK_BITS bytes. Each request is held unchanged while `flush_ready` is low.
- R6: In the cycle after the last flush is accepted, a still-pending cross-core request is accepted with `resp_coherent` high.
- R7: Any access to a shared page, including one from the former owner, completes in the same cycle with `resp_coherent` high; a shared page is never reported private again while its record exists.
- R8: Classification covers all addresses with equal bits [ADDR_W-1:PAGE_BITS]; pages with different numbers are classified independently.
- R9: A miss with every slot valid evicts entries in round-robin order starting at slot 0. A shared victim is replaced in the same cycle and the new page becomes private. A private victim is first flushed from its owner in full (as in R5), and then the new page is installed as private and the request completes non-coherent.
- R10: An evicted page keeps no record: its next access is treated as a first access, and the former owner gains no rights over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_core | input | CORE_W | Requesting core ID |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Request accepted this cycle (low while stalled) |
| resp_coherent | output | 1 | Accepted access needs coherence tracking |
| flush_valid | output | 1 | Flush request to a core cache |
| flush_core | output | CORE_W | Core whose cache must flush |
| flush_addr | output | ADDR_W | Block-aligned address to flush |
| flush_ready | input | 1 | Owner accepts the current flush request |

## Verification
The hardest state to reach is eviction of a private victim. The stimulus fills all slots, turns one entry shared through a full cross-core recovery, and then makes a shared eviction so that the round-robin pointer advances. Only after that does a second miss land on a private slot and force a flush of a page other than the one being requested. The bench then revisits the evicted page from a new core and afterwards from its former owner. This shows that the record is gone and that ownership restarts from scratch. Recoveries are also run with `flush_ready` held low at scattered blocks, to check that the flush address holds steady under back-pressure.

// File: rtl/pst_pkg.sv
package pst_pkg;
  // Outcome of one table lookup for the request presented this cycle.
  typedef enum logic [2:0] {
    LK_SHARED    = 3'd0,  // hit on shared page
    LK_OWNED     = 3'd1,  // hit on private page, requester is owner
    LK_CROSS     = 3'd2,  // hit on private page, requester is another core
    LK_ALLOC     = 3'd3,  // miss, free slot available
    LK_EVICT_SH  = 3'd4,  // miss, table full, victim is shared
    LK_EVICT_PRV = 3'd5   // miss, table full, victim is private
  } lookup_e;
endpackage

// File: rtl/pst_table.sv
module pst_table #(
  parameter int ENTRIES = 4,
  parameter int CORE_W  = 2,
  parameter int PAGE_W  = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              hit_shared,
  output logic [CORE_W-1:0] hit_owner,
  output logic              free_avail,
  output logic [IDX_W-1:0]  free_idx,
  output logic [IDX_W-1:0]  victim_idx,
  output logic              victim_shared,
  output logic [CORE_W-1:0] victim_owner,
  output logic [PAGE_W-1:0] victim_page,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic [CORE_W-1:0] wr_owner,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              adv_ptr
);
  logic [ENTRIES-1:0] valid_q, shared_q, match;
  logic [CORE_W-1:0]  owner_q [ENTRIES];
  logic [PAGE_W-1:0]  page_q  [ENTRIES];
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  // Per-slot storage with explicit write enable.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic we;
    assign we       = wr_en && (wr_idx == IDX_W'(e));
    assign match[e] = valid_q[e] && (page_q[e] == lk_page);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e]  <= 1'b0;
        shared_q[e] <= 1'b0;
        owner_q[e]  <= '0;
        page_q[e]   <= '0;
      end else if (we) begin
        valid_q[e]  <= wr_valid;
        shared_q[e] <= wr_shared;
        owner_q[e]  <= wr_owner;
        page_q[e]   <= wr_page;
      end
    end
  end

  // Hit and free-slot priority encoders (lowest index wins).
  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    free_avail = 1'b0;
    free_idx   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(e);
      end
      if (!valid_q[e]) begin
        free_avail = 1'b1;
        free_idx   = IDX_W'(e);
      end
    end
  end

  assign hit_shared    = shared_q[hit_idx];
  assign hit_owner     = owner_q[hit_idx];
  assign victim_idx    = ptr_q;
  assign victim_shared = shared_q[ptr_q];
  assign victim_owner  = owner_q[ptr_q];
  assign victim_page   = page_q[ptr_q];

  // Round-robin victim pointer.
  always_comb begin
    ptr_d = ptr_q;
    if (adv_ptr) begin
      ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/pst_flush_seq.sv
module pst_flush_seq #(
  parameter int CORE_W = 2,
  parameter int PAGE_W = 20,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CORE_W-1:0] start_core,
  input  logic              fl_ready,
  output logic              fl_active,
  output logic [PAGE_W-1:0] fl_page,
  output logic [BLK_W-1:0]  fl_blk,
  output logic [CORE_W-1:0] fl_core
);
  logic              active_q, active_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [CORE_W-1:0] core_q, core_d;

  always_comb begin
    active_d = active_q;
    blk_d    = blk_q;
    page_d   = page_q;
    core_d   = core_q;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        blk_d    = '0;
        page_d   = start_page;
        core_d   = start_core;
      end
    end else if (fl_ready) begin
      if (&blk_q) active_d = 1'b0;
      else        blk_d    = blk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      blk_q    <= '0;
      page_q   <= '0;
      core_q   <= '0;
    end else begin
      active_q <= active_d;
      blk_q    <= blk_d;
      page_q   <= page_d;
      core_q   <= core_d;
    end
  end

  assign fl_active = active_q;
  assign fl_page   = page_q;
  assign fl_blk    = blk_q;
  assign fl_core   = core_q;
endmodule

// File: rtl/page_share_classifier.sv
module page_share_classifier
  import pst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CORE_W     = 2,
  parameter int PAGE_BITS  = 12,
  parameter int BLOCK_BITS = 6,
  parameter int ENTRIES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_coherent,
  output logic              flush_valid,
  output logic [CORE_W-1:0] flush_core,
  output logic [ADDR_W-1:0] flush_addr,
  input  logic              flush_ready
);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;
  localparam int BLK_W  = PAGE_BITS - BLOCK_BITS;
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [PAGE_W-1:0] page;
  logic              unused_offset;
  assign page          = req_addr[ADDR_W-1:PAGE_BITS];
  assign unused_offset = ^req_addr[PAGE_BITS-1:0];

  logic              hit, hit_shared, free_avail, victim_shared;
  logic [IDX_W-1:0]  hit_idx, free_idx, victim_idx;
  logic [CORE_W-1:0] hit_owner, victim_owner;
  logic [PAGE_W-1:0] victim_page;
  logic              wr_en, wr_valid, wr_shared, adv_ptr;
  logic [IDX_W-1:0]  wr_idx;
  logic [CORE_W-1:0] wr_owner;
  logic              fl_start;
  logic [PAGE_W-1:0] fl_start_page, fl_page;
  logic [CORE_W-1:0] fl_start_core;
  logic [BLK_W-1:0]  fl_blk;
  logic              busy, go;
  lookup_e           outcome;

  pst_table #(.ENTRIES(ENTRIES), .CORE_W(CORE_W), .PAGE_W(PAGE_W)) u_table (
    .clk, .rst_n,
    .lk_page(page),
    .hit, .hit_idx, .hit_shared, .hit_owner,
    .free_avail, .free_idx,
    .victim_idx, .victim_shared, .victim_owner, .victim_page,
    .wr_en, .wr_idx, .wr_valid, .wr_shared, .wr_owner,
    .wr_page(page),
    .adv_ptr
  );

  pst_flush_seq #(.CORE_W(CORE_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_seq (
    .clk, .rst_n,
    .start(fl_start), .start_page(fl_start_page), .start_core(fl_start_core),
    .fl_ready(flush_ready),
    .fl_active(busy), .fl_page, .fl_blk, .fl_core(flush_core)
  );

  // Classify the presented request.
  always_comb begin
    if (hit) begin
      if (hit_shared)             outcome = LK_SHARED;
      else if (hit_owner == req_core) outcome = LK_OWNED;
      else                        outcome = LK_CROSS;
    end else if (free_avail)      outcome = LK_ALLOC;
    else if (victim_shared)       outcome = LK_EVICT_SH;
    else                          outcome = LK_EVICT_PRV;
  end

  assign go = req_valid && !busy;

  // Table update, pointer advance and recovery launch.
  always_comb begin
    wr_en         = 1'b0;
    wr_idx        = free_idx;
    wr_valid      = 1'b1;
    wr_shared     = 1'b0;
    wr_owner      = req_core;
    adv_ptr       = 1'b0;
    fl_start      = 1'b0;
    fl_start_page = page;
    fl_start_core = hit_owner;
    if (go) begin
      unique case (outcome)
        LK_CROSS: begin
          wr_en     = 1'b1;
          wr_idx    = hit_idx;
          wr_shared = 1'b1;
          wr_owner  = hit_owner;
          fl_start  = 1'b1;
        end
        LK_ALLOC: wr_en = 1'b1;
        LK_EVICT_SH: begin
          wr_en   = 1'b1;
          wr_idx  = victim_idx;
          adv_ptr = 1'b1;
        end
        LK_EVICT_PRV: begin
          wr_en         = 1'b1;
          wr_idx        = victim_idx;
          wr_valid      = 1'b0;
          adv_ptr       = 1'b1;
          fl_start      = 1'b1;
          fl_start_page = victim_page;
          fl_start_core = victim_owner;
        end
        default: ;
      endcase
    end
  end

  assign req_ready     = !busy && (!req_valid || outcome == LK_SHARED || outcome == LK_OWNED
                                   || outcome == LK_ALLOC || outcome == LK_EVICT_SH);
  assign resp_coherent = go && (outcome == LK_SHARED);
  assign flush_valid   = busy;
  assign flush_addr    = {fl_page, fl_blk, {BLOCK_BITS{1'b0}}};
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int ADDR_W     = 32,
  parameter int CORE_W     = 2,
  parameter int PAGE_BITS  = 12,
  parameter int BLOCK_BITS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              flush_valid,
  input logic              flush_ready,
  input logic [CORE_W-1:0] flush_core,
  input logic [ADDR_W-1:0] flush_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BLOCK_BITS;

  // R4: request is never accepted while a recovery is running
  a_r4_stall_while_flushing: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !req_ready);

  // R4: a recovery only starts from a presented request
  a_r4_flush_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_valid) |-> $past(req_valid));

  // R5: recovery begins at block 0 of the page
  a_r5_first_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_valid) |-> flush_addr[PAGE_BITS-1:0] == '0);

  // R5: request holds under back-pressure
  a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_ready) |=> flush_valid && $stable(flush_addr) && $stable(flush_core));

  // R5: each accepted flush is followed by the next block or by the end of recovery
  a_r5_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_ready) |=> !flush_valid || (flush_addr == $past(flush_addr) + STEP));

  // R6: a pending request is released right after recovery ends
  a_r6_release_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_valid) && req_valid) |-> req_ready);
endmodule

bind page_share_classifier pst_checker #(
  .ADDR_W(ADDR_W), .CORE_W(CORE_W), .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .flush_valid(flush_valid), .flush_ready(flush_ready),
  .flush_core(flush_core), .flush_addr(flush_addr)
);

// File: tb/tb_page_share_classifier.sv
module tb_page_share_classifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_core;
  logic [31:0] req_addr;
  logic        req_ready, resp_coherent, flush_valid, flush_ready;
  logic [1:0]  flush_core;
  logic [31:0] flush_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  page_share_classifier dut (
    .clk, .rst_n, .req_valid, .req_core, .req_addr, .req_ready, .resp_coherent,
    .flush_valid, .flush_core, .flush_addr, .flush_ready
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_addr = '0; flush_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1,   "R1 ready after reset", 32'(req_ready), 1);
    chk(flush_valid == 1'b0, "R1 no flush after reset", 32'(flush_valid), 0);
  endtask

  // One access expected to complete in its first cycle.
  task automatic acc(input logic [1:0] core, input logic [31:0] addr, input bit exp_coh, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_core = core; req_addr = addr;
    #1;
    chk(req_ready == 1'b1,       {tag, " ready"},    32'(req_ready), 1);
    chk(resp_coherent == exp_coh, {tag, " coherent"}, 32'(resp_coherent), 32'(exp_coh));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // An access that triggers a full recovery of page fbase from core owner.
  task automatic stalled(input logic [1:0] core, input logic [31:0] addr, input logic [31:0] fbase,
                         input logic [1:0] owner, input bit bp, input bit exp_coh, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_core = core; req_addr = addr; flush_ready = 1'b0;
    #1;
    chk(req_ready == 1'b0, {tag, " R4 stall first cycle"}, 32'(req_ready), 0);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (bp && (i % 16 == 3)) begin
        flush_ready = 1'b0;
        #1;
        chk(flush_valid && flush_addr == fbase + 32'(i * 64), {tag, " R5 held addr"}, flush_addr, fbase + 32'(i * 64));
        @(negedge clk);
      end
      flush_ready = 1'b1;
      #1;
      chk(flush_valid == 1'b1,           {tag, " R5 flush valid"}, 32'(flush_valid), 1);
      chk(flush_addr == fbase + 32'(i * 64), {tag, " R5 flush addr"}, flush_addr, fbase + 32'(i * 64));
      chk(flush_core == owner,           {tag, " R5 flush core"}, 32'(flush_core), 32'(owner));
      chk(req_ready == 1'b0,             {tag, " R4 stalled"}, 32'(req_ready), 0);
    end
    @(negedge clk);
    flush_ready = 1'b0;
    #1;
    chk(flush_valid == 1'b0,       {tag, " R5 count ends at 64"}, 32'(flush_valid), 0);
    chk(req_ready == 1'b1,         {tag, " R6 released"}, 32'(req_ready), 1);
    chk(resp_coherent == exp_coh,  {tag, " R6 coherent after"}, 32'(resp_coherent), 32'(exp_coh));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R1, R2, R3: first touch and owner reuse
  task automatic t_first_touch();
    t_reset();
    acc(2'd1, 32'h0000_5000, 1'b0, "R1 first access non-coherent");
    acc(2'd1, 32'h0000_5abc, 1'b0, "R3 owner again");
    acc(2'd2, 32'h0000_6000, 1'b0, "R2 second page new owner");
    acc(2'd2, 32'h0000_6ff8, 1'b0, "R3 second owner again");
  endtask

  // R4..R8: page granularity, cross-core recovery with back-pressure, shared forever
  task automatic t_cross();
    t_reset();
    acc(2'd0, 32'h0000_1000, 1'b0, "R2 alloc page 1");
    acc(2'd0, 32'h0000_1fc0, 1'b0, "R8 same page other block");
    acc(2'd1, 32'h0000_2000, 1'b0, "R8 neighbour page independent");
    stalled(2'd1, 32'h0000_1040, 32'h0000_1000, 2'd0, 1'b1, 1'b1, "R4 cross page 1");
    acc(2'd0, 32'h0000_1abc, 1'b1, "R7 old owner sees shared");
    acc(2'd3, 32'h0000_1000, 1'b1, "R7 third core shared");
    acc(2'd0, 32'h0000_1004, 1'b1, "R7 stays shared");
    acc(2'd1, 32'h0000_2040, 1'b0, "R8 page 2 still private");
  endtask

  // R9, R10: round-robin eviction of shared and private victims
  task automatic t_evict();
    t_reset();
    acc(2'd0, 32'h0001_0000, 1'b0, "R2 fill slot 0");
    acc(2'd0, 32'h0001_1000, 1'b0, "R2 fill slot 1");
    acc(2'd0, 32'h0001_2000, 1'b0, "R2 fill slot 2");
    acc(2'd0, 32'h0001_3000, 1'b0, "R2 fill slot 3");
    stalled(2'd1, 32'h0001_0000, 32'h0001_0000, 2'd0, 1'b0, 1'b1, "R9 share slot 0");
    acc(2'd2, 32'h0001_4000, 1'b0, "R9 shared victim replaced at once");
    stalled(2'd1, 32'h0001_5000, 32'h0001_1000, 2'd0, 1'b0, 1'b0, "R9 private victim flushed");
    acc(2'd1, 32'h0001_5080, 1'b0, "R9 new page private to requester");
    stalled(2'd3, 32'h0001_1040, 32'h0001_2000, 2'd0, 1'b1, 1'b0, "R10 evicted page is first access");
    acc(2'd3, 32'h0001_1000, 1'b0, "R10 new owner of evicted page");
    acc(2'd2, 32'h0001_4100, 1'b0, "R9 slot 0 page kept");
    stalled(2'd0, 32'h0001_1000, 32'h0001_1000, 2'd3, 1'b0, 1'b1, "R10 former owner now foreign");
  endtask

  initial begin
    t_first_touch();
    t_cross();
    t_evict();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule